// File: doc/BRIEF.md
# Array Floating-Point Divider

This block divides two floating-point operands that share one parameterised format (a sign bit, an exponent field and a stored-fraction field with an implicit leading one). With the default parameters a word is 16 bits: bit 15 is the sign, bits 14:7 hold the biased exponent (bias 127) and bits 6:0 hold the fraction. The sign, exponent and fraction of the quotient come from three separate paths that meet only in a final merge stage.

The fraction comes from a fixed array of subtract-and-select rows, one row for each quotient bit. It uses no reciprocal, no multiplier and no iteration. Each row subtracts the divisor significand from the partial remainder it receives. The row's carry-out becomes its quotient bit, and the same carry-out chooses whether the difference or the unchanged remainder moves on, shifted one place, to the next row. The exponent path subtracts the divisor exponent from the dividend exponent and adds the bias back in. The sign is the XOR of the operand signs.

A two-register pipeline surrounds the array. Operands are captured when `inValid` is high, and the merged result appears with `outValid` two clock cycles later. Underflow, overflow and zero operands follow a simple saturating policy. The fraction is truncated, with no rounding.

Top module: `fp_array_div`

## Requirements
- R1: The quotient sign (bit W-1) is the XOR of the two operand sign bits, in every case, saturated results included.
- R2: When the dividend significand is not smaller than the divisor significand, the fraction field is the truncated significand ratio with its leading one removed, and the exponent field is expA - expB + bias.
- R3: When the dividend significand is smaller than the divisor significand, the quotient is normalised by one left shift: the fraction keeps one more quotient bit, and the exponent field is expA - expB + bias - 1.
- R4: Operands whose significands are equal produce a zero fraction field and the exponent field expA - expB + bias.
- R5: A computed exponent below 0 gives a result whose exponent and fraction fields are all zero.
- R6: A computed exponent above 2^EXP-1 gives the all-ones exponent field and a zero fraction field.
- R7: A divisor whose exponent field is 0 gives the all-ones exponent and a zero fraction, whatever the dividend is.
- R8: A dividend whose exponent field is 0, with a nonzero divisor exponent, gives all-zero exponent and fraction fields.
- R9: `outValid` goes high exactly two cycles after `inValid` is sampled high. Back-to-back operands produce results on consecutive cycles.
- R10: After reset, `outValid` is 0 and `quot` is 0. While no new operand is accepted, `quot` holds its last value, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands are valid this cycle |
| opA | input | W | Dividend |
| opB | input | W | Divisor |
| outValid | output | 1 | quot holds a new result |
| quot | output | W | Quotient |

## Verification
The hardest case to reach is the normalisation branch, where the significand ratio falls below one, combined with an exponent that lands exactly on a saturation limit. Random operands seldom reach that combination. Directed operands with chosen fractions (for example 1/3) drive the array into the shifted-result branch. Chosen exponent pairs push the exponent path past its lower and upper limits. A sweep with narrowed exponents then exercises both branches many times against an integer reference.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic loadIn;   // capture operands into the first stage
    logic loadOut;  // capture the merged result into the output stage
  } fpdivStb_t;
endpackage

// File: rtl/fpdiv_array.sv
// Non-iterative restoring division array: one subtract-and-select row per quotient bit
module fpdiv_array #(
  parameter int MAN = 7
) (
  input  logic [MAN:0]   dividend,   // significand with hidden one
  input  logic [MAN:0]   divisor,    // significand with hidden one
  output logic [MAN+1:0] quoBits
);
  localparam int QW = MAN + 2;   // quotient bits produced
  localparam int RW = MAN + 2;   // partial remainder width

  logic [QW-1:0][RW-1:0] part;
  logic [QW-2:0][RW-1:0] rem;

  for (genvar k = 0; k < QW; k++) begin : gRow
    logic [RW:0] diff;
    if (k == 0) begin : gFirst
      assign part[k] = {1'b0, dividend};
    end else begin : gNext
      // remainder is below the divisor, so its top bit is zero; shift one place
      assign part[k] = {rem[k-1][RW-2:0], 1'b0};
    end
    assign diff = {1'b0, part[k]} - {2'b00, divisor};
    // carry-out (no borrow) selects the quotient bit
    assign quoBits[QW-1-k] = ~diff[RW];
    if (k < QW - 1) begin : gPass
      assign rem[k] = diff[RW] ? part[k] : diff[RW-1:0];
    end
  end
endmodule

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl
  import fpdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output fpdivStb_t stb,
  output logic      outValid
);
  logic [1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= 2'b00;
    else       validPipe <= {validPipe[0], inValid};
  end

  always_comb begin
    stb.loadIn  = inValid;
    stb.loadOut = validPipe[0];
  end

  assign outValid = validPipe[1];

  // R9
  stage_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.loadOut));
endmodule

// File: rtl/fpdiv_datapath.sv
module fpdiv_datapath
  import fpdiv_pkg::*;
#(
  parameter int EXP = 8,
  parameter int MAN = 7,
  parameter int W   = 1 + EXP + MAN
) (
  input  logic         clk,
  input  logic         rstN,
  input  fpdivStb_t    stb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] quot
);
  localparam int QW   = MAN + 2;
  localparam int EW   = EXP + 2;
  localparam int BIAS = (1 << (EXP - 1)) - 1;
  localparam logic signed [EW-1:0] EXP_TOP = EW'((1 << EXP) - 1);

  logic [W-1:0] aReg, bReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (stb.loadIn) begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  // field split
  logic           signA, signB;
  logic [EXP-1:0] expA, expB;
  logic [MAN-1:0] fracA, fracB;
  assign {signA, expA, fracA} = aReg;
  assign {signB, expB, fracB} = bReg;

  // fraction path
  logic [QW-1:0]  qRaw;
  logic           norm;
  logic [MAN-1:0] fracQ;

  fpdiv_array #(.MAN(MAN)) uArray (
    .dividend ({1'b1, fracA}),
    .divisor  ({1'b1, fracB}),
    .quoBits  (qRaw)
  );

  assign norm  = qRaw[QW-1];
  assign fracQ = norm ? qRaw[MAN:1] : qRaw[MAN-1:0];

  // exponent path: difference, then bias compensation
  logic signed [EW-1:0] expDiff, expQ;
  assign expDiff = EW'(expA) - EW'(expB);
  assign expQ    = expDiff + EW'(BIAS) - EW'(!norm);

  // sign path
  logic signQ;
  assign signQ = signA ^ signB;

  // merge
  logic [W-1:0] merged;
  always_comb begin
    if (expB == '0)
      merged = {signQ, {EXP{1'b1}}, {MAN{1'b0}}};
    else if (expA == '0)
      merged = {signQ, {(W-1){1'b0}}};
    else if (expQ < 0)
      merged = {signQ, {(W-1){1'b0}}};
    else if (expQ > EXP_TOP)
      merged = {signQ, {EXP{1'b1}}, {MAN{1'b0}}};
    else
      merged = {signQ, expQ[EXP-1:0], fracQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            quot <= '0;
    else if (stb.loadOut) quot <= merged;
  end

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |=> quot[W-1] == $past(aReg[W-1] ^ bReg[W-1]));
  // R3
  quot_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |-> (qRaw[QW-1] | qRaw[QW-2]));
  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadOut && expB == '0) |=> (quot[W-2:0] == {{EXP{1'b1}}, {MAN{1'b0}}}));
  // R8
  zero_dividend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadOut && expA == '0 && expB != '0) |=> (quot[W-2:0] == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> $stable(quot));
endmodule

// File: rtl/fp_array_div.sv
module fp_array_div
  import fpdiv_pkg::*;
#(
  parameter int EXP = 8,
  parameter int MAN = 7,
  parameter int W   = 1 + EXP + MAN
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         outValid,
  output logic [W-1:0] quot
);
  fpdivStb_t stb;

  fpdiv_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  fpdiv_datapath #(.EXP(EXP), .MAN(MAN), .W(W)) uPath (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .opA  (opA),
    .opB  (opB),
    .quot (quot)
  );

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid, 2));
endmodule

// File: tb/tb_fp_array_div.sv
module tb_fp_array_div;
  localparam int EXP = 8;
  localparam int MAN = 7;
  localparam int W   = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         outValid;
  logic [W-1:0] quot;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_array_div #(.EXP(EXP), .MAN(MAN), .W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .quot(quot)
  );

  function automatic logic [15:0] refDiv(input logic [15:0] a, input logic [15:0] b);
    logic s;
    int ea, eb, ma, mb, q, e, f;
    s  = a[15] ^ b[15];
    ea = int'(a[14:7]);
    eb = int'(b[14:7]);
    if (eb == 0) return {s, 8'hFF, 7'h00};
    if (ea == 0) return {s, 15'h0000};
    ma = 128 + int'(a[6:0]);
    mb = 128 + int'(b[6:0]);
    q  = (ma * 256) / mb;
    if (q >= 256) begin f = (q / 2) % 128; e = ea - eb + 127; end
    else          begin f = q % 128;       e = ea - eb + 126; end
    if (e < 0)   return {s, 15'h0000};
    if (e > 255) return {s, 8'hFF, 7'h00};
    return {s, e[7:0], f[6:0]};
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "valid before", {15'd0, outValid}, 16'd0);
    @(negedge clk);
    check(req, "valid", {15'd0, outValid}, 16'd1);
    check(req, "quot", quot, refDiv(a, b));
  endtask

  task automatic testReset();
    check("R10", "reset valid", {15'd0, outValid}, 16'd0);
    check("R10", "reset quot", quot, 16'h0000);
  endtask

  task automatic testBasic();
    runOp("R4", 16'h3F80, 16'h3F80);   // 1/1
    check("R4", "one", quot, 16'h3F80);
    runOp("R2", 16'h40C0, 16'h4000);   // 6/2
    check("R2", "three", quot, 16'h4040);
    runOp("R3", 16'h3F80, 16'h4040);   // 1/3
    check("R3", "third", quot, 16'h3EAA);
  endtask

  task automatic testSign();
    runOp("R1", 16'hC0C0, 16'h4000);
    check("R1", "neg", quot, 16'hC040);
    runOp("R1", 16'hC0C0, 16'hC000);
    check("R1", "negneg", quot, 16'h4040);
  endtask

  task automatic testUnderflow();
    runOp("R5", 16'h8080, 16'h6400);
    check("R5", "under", quot, 16'h8000);
    runOp("R5", 16'h0380, 16'h4040);   // e = 7-128+126 = 5, ratio < 1
  endtask

  task automatic testOverflow();
    runOp("R6", 16'h7F00, 16'h0080);
    check("R6", "over", quot, 16'h7F80);
  endtask

  task automatic testDivZero();
    runOp("R7", 16'h4000, 16'h0000);
    check("R7", "x/0", quot, 16'h7F80);
    runOp("R7", 16'h0000, 16'h0000);
    check("R7", "0/0", quot, 16'h7F80);
    runOp("R7", 16'hC000, 16'h8000);
    check("R7", "neg/neg0", quot, 16'h7F80);
  endtask

  task automatic testZeroDividend();
    runOp("R8", 16'h0000, 16'h4000);
    check("R8", "0/x", quot, 16'h0000);
    runOp("R8", 16'h8000, 16'h4000);
    check("R8", "-0/x", quot, 16'h8000);
  endtask

  task automatic testHold();
    logic [W-1:0] last;
    runOp("R10", 16'h40C0, 16'h4000);
    last = quot;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opA = 16'h1234 + 16'(i); opB = 16'h4321;
    end
    @(negedge clk);
    check("R10", "hold quot", quot, last);
    check("R10", "hold valid", {15'd0, outValid}, 16'd0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    opA = 16'h40C0; opB = 16'h4000; inValid = 1'b1;
    @(negedge clk);
    opA = 16'h3F80; opB = 16'h4040;
    @(negedge clk);
    inValid = 1'b0;
    check("R9", "b2b valid1", {15'd0, outValid}, 16'd1);
    check("R9", "b2b quot1", quot, 16'h4040);
    @(negedge clk);
    check("R9", "b2b valid2", {15'd0, outValid}, 16'd1);
    check("R9", "b2b quot2", quot, 16'h3EAA);
    @(negedge clk);
    check("R9", "b2b idle", {15'd0, outValid}, 16'd0);
  endtask

  task automatic testSweep();
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] a, b;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {lfsr[0], 8'd96 + {2'b00, lfsr[6:1]}, lfsr[13:7]};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = {lfsr[3], 8'd96 + {2'b00, lfsr[9:4]}, lfsr[15:9]};
      if (a[6:0] >= b[6:0]) runOp("R2", a, b);
      else                  runOp("R3", a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testSign();
    testUnderflow();
    testOverflow();
    testDivZero();
    testZeroDividend();
    testHold();
    testBackToBack();
    testSweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule